// File: doc/BRIEF.md
# Delayed One-Shot Pulse Generator

This block turns each qualifying edge on an external trigger line into one output pulse that appears after a programmable delay and lasts for a programmable width. Two linked 16-bit down-counters share the job. The first (delay channel) waits for an edge, loads its reload value and counts down. Its terminal count starts the second (width channel), which loads its own reload value and holds the pulse output active while it runs.

Software configures the pair through a small register port. A self-clearing start bit arms both channels together and a self-clearing stop bit halts them together. Counting advances only on cycles where the count-clock enable is high, so an external prescaler sets the time base. While the pair is armed, the configuration is locked except for the edge selection. With the output enable cleared, software drives the output level directly.

Top module: `dly_pulse_gen`

## Requirements
- R1: After a synchronous reset, pulse_out, pulse_oe, irq_delay and irq_width are 0 and every readable location returns 0.
- R2: A write to address 0 with bit0 (start) set, bit1 (stop) clear and bit5 (output enable) set, while disarmed, sets both enable flags (status bits 7 and 8). Status bits 1:0 always read 0. An armed pair does not count before a trigger edge.
- R3: The trigger passes through a two-flop synchronizer. The edge field (control bits 3:2) selects 00 falling, 01 rising, and 10 or 11 both edges. An edge of another kind is ignored.
- R4: On a qualifying edge while armed, the delay counter loads the delay reload (address 1). It reaches its terminal count on the (D+1)th tick after the load. irq_delay is then high for exactly one cycle, starting the cycle after that tick.
- R5: The width channel loads the width reload W (address 2) in the same cycle as the delay terminal count. On its next tick pulse_out takes the active level (NOT the polarity bit, control bit 4; 1 means active low). W+1 ticks later pulse_out returns to the polarity level and irq_width pulses for one cycle.
- R6: Neither counter changes in a cycle where cnt_tick is low.
- R7: A trigger edge is ignored while either channel is running, and the two channels never run together. A new pulse is armed only once both counters have stopped.
- R8: A write with bit1 (stop) set clears both enable flags and stops both channels. Both counts and pulse_out keep their values. Stop takes priority over start in the same write.
- R9: While armed, writes to addresses 1 and 2 and to control bits 4, 5 and 6 are ignored, but control bits 3:2 are updated.
- R10: While disarmed, a control write with bit5 clear sets pulse_out to control bit 6 on the next cycle. A start with bit5 clear is ignored.
- R11: rd_data is registered and shows the location addressed in the previous cycle. The locations are: 0 status ({w_run, d_run, en, en, pulse_out, oe, pol, edge[1:0], 2'b00}), 1 delay reload, 2 width reload, 3 delay count, 4 width count, and 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Registered read data |
| trig_in | input | 1 | Asynchronous trigger input |
| cnt_tick | input | 1 | Count-clock enable |
| pulse_out | output | 1 | Pulse output level |
| pulse_oe | output | 1 | Output enable for the pulse pin |
| irq_delay | output | 1 | Delay terminal-count strobe |
| irq_width | output | 1 | Width terminal-count strobe |

## Verification
The bench targets zero reload values, where a design counting D ticks instead of D+1 would shorten the delay or produce no pulse. It also drives retriggers during the delay and width phases, which a design without the lockout would answer with restarts or overlapping pulses. A stop issued mid-pulse must leave the output high and the counts frozen, while a design that resets them would drop the level. Writes made while armed must not reach the reloads or the polarity, and an active-low run must invert the level. Sparse ticks stretch every phase, so a counter that ran on every clock would shrink the pulse.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_DRL  = 1;
  localparam int ADDR_WRL  = 2;
  localparam int ADDR_DCNT = 3;
  localparam int ADDR_WCNT = 4;

  localparam int B_START = 0;
  localparam int B_STOP  = 1;
  localparam int B_ESEL  = 2;
  localparam int B_POL   = 4;
  localparam int B_OE    = 5;
  localparam int B_LVL   = 6;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_ANY  = 2'b10
  } edge_sel_e;
endpackage

// File: rtl/dpg_edge_det.sv
module dpg_edge_det #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       din,
  input  logic [1:0] sel,
  output logic       hit
);
  localparam int SL = SYNC + 1;
  logic [SL-1:0] sh_q;
  logic          rise, fall;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SL-2:0], din};
  end

  assign rise = sh_q[SL-2] & ~sh_q[SL-1];
  assign fall = ~sh_q[SL-2] & sh_q[SL-1];

  always_comb begin
    case (sel)
      2'b00:   hit = fall;
      2'b01:   hit = rise;
      default: hit = rise | fall;
    endcase
  end
endmodule

// File: rtl/dpg_counter.sv
module dpg_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic [CW-1:0] cnt,
  output logic          run,
  output logic          hit,
  output logic          done
);
  assign hit = run && tick && (cnt == '0) && !abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= hit;
      if (abort) begin
        run <= 1'b0;
      end else if (load) begin
        cnt <= load_val;
        run <= 1'b1;
      end else if (run && tick) begin
        if (cnt == '0) run <= 1'b0;
        else           cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dly_pulse_gen.sv
module dly_pulse_gen
  import dpg_pkg::*;
#(
  parameter int CW   = 16,
  parameter int AW   = 3,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data,
  input  logic          trig_in,
  input  logic          cnt_tick,
  output logic          pulse_out,
  output logic          pulse_oe,
  output logic          irq_delay,
  output logic          irq_width
);
  localparam int NCH = 2;

  logic          en_q, pol_q, oe_q, out_q, lead_q;
  logic [1:0]    esel_q;
  logic [CW-1:0] drl_q, wrl_q, rd_q;
  logic          ctrl_wr, stop_req, start_req, trig_hit, w_start;

  logic [NCH-1:0]         ch_load, ch_tick, ch_run, ch_hit, ch_done;
  logic [NCH-1:0][CW-1:0] ch_val, ch_cnt;

  dpg_edge_det #(.SYNC(SYNC)) u_edge (
    .clk(clk), .rst(rst), .din(trig_in), .sel(esel_q), .hit(trig_hit)
  );

  assign ctrl_wr   = wr_en && (wr_addr == AW'(ADDR_CTRL));
  assign stop_req  = ctrl_wr && wr_data[B_STOP];
  assign start_req = ctrl_wr && wr_data[B_START] && wr_data[B_OE] && !en_q && !stop_req;

  assign ch_load[0] = en_q && trig_hit && !ch_run[0] && !ch_run[1];
  assign ch_load[1] = ch_hit[0];
  assign ch_val[0]  = drl_q;
  assign ch_val[1]  = wrl_q;
  assign ch_tick[0] = cnt_tick;
  assign ch_tick[1] = cnt_tick && !lead_q;
  assign w_start    = lead_q && cnt_tick && !stop_req;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dpg_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst(rst), .abort(stop_req), .load(ch_load[i]),
      .load_val(ch_val[i]), .tick(ch_tick[i]), .cnt(ch_cnt[i]),
      .run(ch_run[i]), .hit(ch_hit[i]), .done(ch_done[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      esel_q <= 2'b00;
      pol_q  <= 1'b0;
      oe_q   <= 1'b0;
      out_q  <= 1'b0;
      lead_q <= 1'b0;
      drl_q  <= '0;
      wrl_q  <= '0;
    end else begin
      if (stop_req)       en_q <= 1'b0;
      else if (start_req) en_q <= 1'b1;

      if (ctrl_wr) esel_q <= wr_data[B_ESEL +: 2];
      if (ctrl_wr && !en_q) begin
        pol_q <= wr_data[B_POL];
        oe_q  <= wr_data[B_OE];
      end

      if (wr_en && !en_q && wr_addr == AW'(ADDR_DRL)) drl_q <= wr_data;
      if (wr_en && !en_q && wr_addr == AW'(ADDR_WRL)) wrl_q <= wr_data;

      if (stop_req)       lead_q <= 1'b0;
      else if (ch_hit[0]) lead_q <= 1'b1;
      else if (w_start)   lead_q <= 1'b0;

      if (w_start)        out_q <= ~pol_q;
      else if (ch_hit[1]) out_q <= pol_q;
      else if (ctrl_wr && !en_q && !wr_data[B_OE]) out_q <= wr_data[B_LVL];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      case (rd_addr)
        AW'(ADDR_CTRL): rd_q <= CW'({ch_run[1], ch_run[0], en_q, en_q, out_q,
                                    oe_q, pol_q, esel_q, 2'b00});
        AW'(ADDR_DRL):  rd_q <= drl_q;
        AW'(ADDR_WRL):  rd_q <= wrl_q;
        AW'(ADDR_DCNT): rd_q <= ch_cnt[0];
        AW'(ADDR_WCNT): rd_q <= ch_cnt[1];
        default:        rd_q <= '0;
      endcase
    end
  end

  assign rd_data   = rd_q;
  assign pulse_out = out_q;
  assign pulse_oe  = oe_q;
  assign irq_delay = ch_done[0];
  assign irq_width = ch_done[1];
endmodule

// File: rtl/dpg_chk.sv
module dpg_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          run0,
  input logic          run1,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] cnt1,
  input logic [CW-1:0] drl,
  input logic [CW-1:0] wrl,
  input logic          pol,
  input logic          pulse_out,
  input logic          irq_delay,
  input logic          irq_width
);
  // R7
  chan_mutex_chk: assert property (@(posedge clk) disable iff (rst) !(run0 && run1));

  // R8
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !$past(en)) |-> ($stable(cnt0) && $stable(cnt1)));

  // R9
  reload_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en)) |-> ($stable(drl) && $stable(wrl)));

  // R4
  irq_delay_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    irq_delay |=> !irq_delay);

  // R4
  delay_starts_width_chk: assert property (@(posedge clk) disable iff (rst)
    irq_delay |-> run1);

  // R5
  width_end_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_width |-> (pulse_out == pol));
endmodule

bind dly_pulse_gen dpg_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .en(en_q), .run0(ch_run[0]), .run1(ch_run[1]),
  .cnt0(ch_cnt[0]), .cnt1(ch_cnt[1]), .drl(drl_q), .wrl(wrl_q),
  .pol(pol_q), .pulse_out(pulse_out), .irq_delay(irq_delay), .irq_width(irq_width)
);

// File: tb/sim_dly_pulse_gen.sv
module sim_dly_pulse_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1, wr_en = 0, trig_in = 0, cnt_tick = 0;
  logic [2:0]  wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic        pulse_out, pulse_oe, irq_delay, irq_width;

  int total = 0, bad = 0, cycles = 0, tick_mode = 0;
  int n_irqd = 0, n_irqw = 0, n_hi = 0, n_lo = 0;
  bit live = 0, finished = 0;

  dly_pulse_gen u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .trig_in(trig_in), .cnt_tick(cnt_tick),
    .pulse_out(pulse_out), .pulse_oe(pulse_oe), .irq_delay(irq_delay), .irq_width(irq_width)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic        m_s1, m_s2, m_s3, m_en, m_pol, m_oe, m_out, m_lead, m_drun, m_wrun, m_irqd, m_irqw;
  logic [1:0]  m_esel;
  logic [15:0] m_drl, m_wrl, m_dcnt, m_wcnt, m_rd;

  always @(posedge clk) begin
    bit edg, cw, stp, zd, zw;
    logic [15:0] nrd;
    live <= 1;
    if (rst) begin
      {m_s1, m_s2, m_s3, m_en, m_pol, m_oe, m_out, m_lead, m_drun, m_wrun, m_irqd, m_irqw} = '0;
      m_esel = 0; m_drl = 0; m_wrl = 0; m_dcnt = 0; m_wcnt = 0; m_rd = 0;
    end else begin
      if (m_esel == 2'b00)      edg = !m_s2 && m_s3;
      else if (m_esel == 2'b01) edg = m_s2 && !m_s3;
      else                      edg = m_s2 != m_s3;
      cw  = wr_en && wr_addr == 0;
      stp = cw && wr_data[1];
      case (rd_addr)
        0: nrd = {5'd0, m_wrun, m_drun, m_en, m_en, m_out, m_oe, m_pol, m_esel, 2'b00};
        1: nrd = m_drl;
        2: nrd = m_wrl;
        3: nrd = m_dcnt;
        4: nrd = m_wcnt;
        default: nrd = 0;
      endcase
      zd = 0; zw = 0;
      if (!stp) begin
        zd = m_drun && cnt_tick && m_dcnt == 0;
        if (m_en && edg && !m_drun && !m_wrun) begin m_dcnt = m_drl; m_drun = 1; end
        else if (m_drun && cnt_tick) begin
          if (m_dcnt == 0) m_drun = 0; else m_dcnt = m_dcnt - 1;
        end
        if (zd) begin m_wcnt = m_wrl; m_wrun = 1; m_lead = 1; end
        else if (m_wrun && cnt_tick) begin
          if (m_lead) begin m_lead = 0; m_out = !m_pol; end
          else if (m_wcnt == 0) begin m_wrun = 0; m_out = m_pol; zw = 1; end
          else m_wcnt = m_wcnt - 1;
        end
      end else begin
        m_drun = 0; m_wrun = 0; m_lead = 0;
      end
      if (cw && !m_en && !wr_data[5]) m_out = wr_data[6];
      if (wr_en && !m_en && wr_addr == 1) m_drl = wr_data;
      if (wr_en && !m_en && wr_addr == 2) m_wrl = wr_data;
      if (cw) m_esel = wr_data[3:2];
      if (cw && !m_en) begin m_pol = wr_data[4]; m_oe = wr_data[5]; end
      if (stp) m_en = 0;
      else if (cw && wr_data[0] && wr_data[5] && !m_en) m_en = 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = trig_in;
      m_irqd = zd; m_irqw = zw; m_rd = nrd;
    end
  end

  // per-cycle comparison, monitors, tick source, watchdog
  always @(negedge clk) begin
    cycles++;
    cnt_tick <= (tick_mode == 0) ? 1'b1 : (tick_mode == 1) ? (cycles % 3 == 0) : 1'b0;
    if (live && !rst) begin
      chk(pulse_out == m_out, "R5 pulse_out", pulse_out, m_out);
      chk(irq_delay == m_irqd, "R4 irq_delay", irq_delay, m_irqd);
      chk(irq_width == m_irqw, "R5 irq_width", irq_width, m_irqw);
      chk(rd_data == m_rd, "R11 rd_data", rd_data, m_rd);
      if (irq_delay) n_irqd++;
      if (irq_width) n_irqw++;
      if (pulse_out) n_hi++; else n_lo++;
    end
    if (cycles > 150000 && !finished) begin
      chk(0, "watchdog", cycles, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); rd_addr = 3'(a);
    @(negedge clk); v = int'(rd_data);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int v, a, b, k0, w0;
    wait_cyc(3);
    rst = 0;
    @(negedge clk);
    // R1
    chk(pulse_out == 0 && pulse_oe == 0, "R1 outputs", {pulse_out, pulse_oe}, 0);
    chk(irq_delay == 0 && irq_width == 0, "R1 irqs", {irq_delay, irq_width}, 0);
    rd(0, v); chk(v == 0, "R1 status", v, 0);
    rd(4, v); chk(v == 0, "R1 width count", v, 0);

    // R2: arm, rising edge, delay 3, width 2
    wr(1, 3); wr(2, 2); wr(0, 'h25);
    rd(0, v); chk(v == 'h1A4, "R2 status after start", v, 'h1A4);
    wait_cyc(10);
    rd(3, v); chk(v == 0, "R2 no count before edge", v, 0);
    chk(n_irqd == 0, "R2 no irq before edge", n_irqd, 0);

    // R4 R5: one pulse of W+1 ticks
    n_hi = 0; trig_in = 1; wait_cyc(30);
    chk(n_irqd == 1, "R4 one delay strobe", n_irqd, 1);
    chk(n_irqw == 1, "R5 one width strobe", n_irqw, 1);
    chk(n_hi == 3, "R5 pulse length", n_hi, 3);

    // R3: falling edge ignored with rising select
    trig_in = 0; wait_cyc(30);
    chk(n_irqd == 1, "R3 falling ignored", n_irqd, 1);

    // R6: sparse ticks stretch the pulse
    tick_mode = 1; n_hi = 0; trig_in = 1; wait_cyc(80);
    chk(n_hi == 9, "R6 pulse with sparse ticks", n_hi, 9);
    tick_mode = 2; trig_in = 0; wait_cyc(5);
    // R3: select falling while armed; rise ignored, fall accepted
    wr(0, 'h20); trig_in = 1; wait_cyc(10);
    rd(3, a); wait_cyc(20); rd(3, b);
    chk(a == b, "R6 count frozen without ticks", b, a);
    tick_mode = 0; wait_cyc(30);
    chk(n_irqd == 2, "R3 rising ignored with falling select", n_irqd, 2);
    trig_in = 0; wait_cyc(30);
    chk(n_irqd == 3, "R3 falling accepted", n_irqd, 3);

    // R7 R9: retrigger lockout and write lock
    wr(0, 'h0A); wr(1, 20); wr(2, 1); wr(0, 'h29);
    wr(1, 7); rd(1, v); chk(v == 20, "R9 reload locked", v, 20);
    wr(0, 'h34); rd(0, v); chk(v == 'h1A4, "R9 only edge field updated", v, 'h1A4);
    wr(0, 'h28);
    k0 = n_irqd; w0 = n_irqw;
    trig_in = 1; wait_cyc(8); trig_in = 0; wait_cyc(8); trig_in = 1; wait_cyc(60);
    chk(n_irqd == k0 + 1, "R7 retrigger ignored", n_irqd, k0 + 1);
    chk(n_irqw == w0 + 1, "R7 single width run", n_irqw, w0 + 1);
    trig_in = 0; wait_cyc(40);
    chk(n_irqd == k0 + 2, "R7 rearmed after both stop", n_irqd, k0 + 2);

    // R8: stop in mid pulse
    wr(0, 'h0A); wr(1, 1); wr(2, 40); wr(0, 'h29);
    trig_in = 1;
    for (int i = 0; i < 50 && !pulse_out; i++) @(negedge clk);
    wait_cyc(5); wr(0, 'h0A); wait_cyc(3);
    rd(0, v); chk((v & 'h180) == 0, "R8 enable flags cleared", v & 'h180, 0);
    chk(pulse_out == 1, "R8 output level held", pulse_out, 1);
    rd(4, a); wait_cyc(10); rd(4, b);
    chk(a == b && a > 0 && a < 40, "R8 width count held", b, a);

    // R10: direct level control, start refused without enable
    wr(0, 'h00); @(negedge clk); chk(pulse_out == 0, "R10 level 0", pulse_out, 0);
    wr(0, 'h40); chk(pulse_out == 1, "R10 level 1", pulse_out, 1);
    wr(0, 'h41); rd(0, v); chk(v == 'h40, "R10 start ignored", v, 'h40);
    k0 = n_irqd; trig_in = 0; wait_cyc(20);
    chk(n_irqd == k0, "R10 no pulse while disarmed", n_irqd, k0);

    // R8: stop wins over start
    wr(0, 'h23); rd(0, v); chk(v == 'h60, "R8 stop beats start", v, 'h60);

    // R5: active-low, zero reloads
    wr(1, 0); wr(2, 0); wr(0, 'h39);
    w0 = n_irqw; wait_cyc(2); n_lo = 0; trig_in = 1; wait_cyc(20);
    chk(n_lo == 1, "R5 active-low one tick", n_lo, 1);
    chk(n_irqw == w0 + 1, "R5 width strobe active-low", n_irqw, w0 + 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule